// File: doc/BRIEF.md
# Single-Precision to Signed 32-Bit Integer Converter

This block turns one IEEE single-precision operand into a signed 32-bit integer, one operand per strobe. The caller chooses between two conversion flavours with a select bit. The first rounds with a 2-bit rounding-mode field taken from the caller's control state. The second always drops the fraction, rounding toward zero, whatever that field holds.

Operands that have no representable integer are reported as invalid. These are NaNs, infinities, and magnitudes that exceed the 32-bit signed range once rounded. With the invalid mask bit set, such an operand produces the integer-indefinite pattern 0x80000000, and the result is written. With the mask bit clear, no write occurs, the result register keeps its previous contents, and a trap request is raised alongside the invalid flag.

Results appear one clock after the input strobe, together with a completion strobe and a write enable.

Top module: `f2i_conv`

## Requirements
- R1: A strobe on `in_valid` produces `out_done` exactly one clock later. A cycle without the strobe produces no `out_done` one clock later.
- R2: With `trunc_sel`=0 and `rmode`=00, the operand rounds to the nearest integer, and an exact tie goes to the even integer (2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R3: With `trunc_sel`=0, `rmode`=01 rounds toward minus infinity, 10 rounds toward plus infinity and 11 rounds toward zero.
- R4: With `trunc_sel`=1, the conversion rounds toward zero for every value of `rmode`.
- R5: An operand whose exponent field (bits 30:23) is all ones (NaN or infinity) is invalid.
- R6: The range test is applied after rounding. A rounded magnitude above 0x7FFFFFFF is invalid, so +2^31 is invalid, while an exact -2^31 converts to 0x80000000 without the invalid flag.
- R7: An invalid operand with `inv_mask`=1 gives `out_we`=1, `out_inv`=1, `out_trap`=0 and `out_data`=0x80000000.
- R8: An invalid operand with `inv_mask`=0 gives `out_we`=0, `out_inv`=1 and `out_trap`=1, and `out_data` keeps the value of the last write.
- R9: Zeros and denormals (exponent field 0) never raise invalid. They convert to 0, except that rounding toward plus infinity turns a positive nonzero denormal into 1, and rounding toward minus infinity turns a negative nonzero denormal into -1 (0xFFFFFFFF).
- R10: `out_we`, `out_inv` and `out_trap` are asserted only in a cycle where `out_done` is high. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Single-precision operand |
| trunc_sel | input | 1 | 1: convert toward zero, ignoring `rmode` |
| rmode | input | 2 | 00 nearest-even, 01 toward -inf, 10 toward +inf, 11 toward zero |
| inv_mask | input | 1 | 1: invalid is masked and the indefinite value is written |
| out_done | output | 1 | Result cycle strobe |
| out_we | output | 1 | `out_data` was written this cycle |
| out_data | output | 32 | Converted integer, held between writes |
| out_inv | output | 1 | Invalid-operation flag for this result |
| out_trap | output | 1 | Trap request for an unmasked invalid operation |

## Verification
The bench sweeps every exponent with several fraction patterns, both signs and all five rounding choices. It compares each result against exact real-valued arithmetic, so the following faults show up as wrong integers:
- a guard or sticky bit lost in the right shift, which would misround halfway cases and tiny denormals;
- a tie broken away from even;
- a directed mode that ignores the sign.

The operands at the range edge, +2^31 and -2^31, are aimed at an off-by-one range test, which would either flag the legal minimum or let +2^31 wrap to a negative number. A pass with the mask cleared catches a design that writes the indefinite value, or anything else, when it should hold the destination and request a trap.

// File: rtl/f2i_pkg.sv
// Shared types for the float-to-integer converter.
// Assumes the 2-bit rounding-mode encoding given in the brief.
package f2i_pkg;
    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;
endpackage

// File: rtl/f2i_unpack.sv
// Splits a binary floating-point word into sign, effective exponent and
// significand. It also flags NaN/infinity and the one exact value equal to
// the most negative integer.
// Assumes IEEE layout: sign on top, then the exponent, then the fraction.
module f2i_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32
) (
    input  logic [EXP_W+FRAC_W:0] fbits,
    output logic                  sign,
    output logic [EXP_W-1:0]      exp_eff,
    output logic [FRAC_W:0]       sig,
    output logic                  special,
    output logic                  min_exact
);
    localparam int BIAS = (1 << (EXP_W-1)) - 1;
    localparam logic [EXP_W-1:0] MIN_EXP = EXP_W'(BIAS + INT_W - 1);

    logic [EXP_W-1:0]  exp_raw;
    logic [FRAC_W-1:0] frac;

    // Field extraction, hidden-bit insertion and classification.
    always_comb begin
        sign      = fbits[EXP_W+FRAC_W];
        exp_raw   = fbits[EXP_W+FRAC_W-1 -: EXP_W];
        frac      = fbits[FRAC_W-1:0];
        exp_eff   = (exp_raw == '0) ? EXP_W'(1) : exp_raw;
        sig       = {(exp_raw != '0), frac};
        special   = &exp_raw;
        min_exact = sign && (exp_raw == MIN_EXP) && (frac == '0);
    end
endmodule

// File: rtl/f2i_shift_round.sv
// Aligns the significand to the integer binary point and rounds the
// magnitude in the requested mode.
// Right shifts keep guard and sticky bits. Left shifts are exact. Exponents
// whose value could not fit the integer are reported as 'huge', and no
// magnitude is produced for them.
module f2i_shift_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32
) (
    input  logic                sign,
    input  logic [EXP_W-1:0]    exp_eff,
    input  logic [FRAC_W:0]     sig,
    input  f2i_pkg::rmode_e     rm,
    output logic [INT_W-1:0]    mag,
    output logic                huge
);
    import f2i_pkg::*;

    localparam int EW1  = EXP_W + 1;
    localparam int BIAS = (1 << (EXP_W-1)) - 1;
    localparam int SW   = 2*FRAC_W + 4;
    localparam logic [EW1-1:0] BIG_E  = EW1'(BIAS + INT_W - 1);
    localparam logic [EW1-1:0] PT_E   = EW1'(BIAS + FRAC_W);
    localparam logic [EW1-1:0] RS_CAP = EW1'(FRAC_W + 3);

    logic [EW1-1:0]   e_x;
    logic [EW1-1:0]   rs;
    logic [SW-1:0]    vec;
    logic [INT_W-1:0] base;
    logic             guard;
    logic             sticky;
    logic             inc;

    // Alignment: exact left shift, or right shift into guard and sticky.
    always_comb begin
        e_x    = {1'b0, exp_eff};
        huge   = (e_x >= BIG_E);
        rs     = '0;
        vec    = '0;
        base   = '0;
        guard  = 1'b0;
        sticky = 1'b0;
        if (!huge && e_x >= PT_E) begin
            base = INT_W'(sig) << (e_x - PT_E);
        end else if (!huge) begin
            rs = PT_E - e_x;
            if (rs > RS_CAP) rs = RS_CAP;
            vec    = {sig, {(FRAC_W+3){1'b0}}} >> rs;
            base   = INT_W'(vec[SW-1 -: FRAC_W+1]);
            guard  = vec[FRAC_W+2];
            sticky = |vec[FRAC_W+1:0];
        end
    end

    // Increment decision for the selected rounding mode.
    always_comb begin
        unique case (rm)
            RM_NEAR: inc = guard && (sticky || base[0]);
            RM_DOWN: inc = sign && (guard || sticky);
            RM_UP:   inc = !sign && (guard || sticky);
            default: inc = 1'b0;
        endcase
        mag = base + INT_W'(inc);
    end
endmodule

// File: rtl/f2i_result.sv
// Range test on the rounded magnitude and two's-complement sign
// application. Every invalid case collapses to the indefinite value.
// Assumes the magnitude has already been rounded.
module f2i_result #(
    parameter int INT_W = 32
) (
    input  logic             sign,
    input  logic             special,
    input  logic             huge,
    input  logic             min_exact,
    input  logic [INT_W-1:0] mag,
    output logic             invalid,
    output logic [INT_W-1:0] value
);
    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] MAXP  = {1'b0, {(INT_W-1){1'b1}}};

    logic over;

    // Signed range limits and final value selection.
    always_comb begin
        over    = sign ? (mag > INDEF) : (mag > MAXP);
        invalid = special || (huge && !min_exact) || (!huge && over);
        if (invalid || min_exact) value = INDEF;
        else if (sign)            value = -mag;
        else                      value = mag;
    end
endmodule

// File: rtl/f2i_conv.sv
// Top level: converts a floating-point operand to a signed integer with one
// clock of latency.
// A masked invalid writes the indefinite value. An unmasked invalid
// suppresses the write, holds out_data and raises a trap request.
// Assumes in_valid is a single-cycle strobe per operand.
module f2i_conv #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [EXP_W+FRAC_W:0]    in_data,
    input  logic                     trunc_sel,
    input  logic [1:0]               rmode,
    input  logic                     inv_mask,
    output logic                     out_done,
    output logic                     out_we,
    output logic [INT_W-1:0]         out_data,
    output logic                     out_inv,
    output logic                     out_trap
);
    import f2i_pkg::*;

    logic             sign;
    logic [EXP_W-1:0] exp_eff;
    logic [FRAC_W:0]  sig;
    logic             special;
    logic             min_exact;
    logic [INT_W-1:0] mag;
    logic             huge;
    logic             invalid;
    logic [INT_W-1:0] value;
    rmode_e           rm_eff;
    logic             trap_now;

    // The truncating flavour overrides the programmed rounding mode.
    always_comb begin
        rm_eff   = trunc_sel ? RM_ZERO : rmode_e'(rmode);
        trap_now = invalid && !inv_mask;
    end

    f2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_unpack (
        .fbits(in_data), .sign(sign), .exp_eff(exp_eff), .sig(sig),
        .special(special), .min_exact(min_exact)
    );

    f2i_shift_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_round (
        .sign(sign), .exp_eff(exp_eff), .sig(sig), .rm(rm_eff),
        .mag(mag), .huge(huge)
    );

    f2i_result #(.INT_W(INT_W)) u_result (
        .sign(sign), .special(special), .huge(huge), .min_exact(min_exact),
        .mag(mag), .invalid(invalid), .value(value)
    );

    // Output register stage: strobes, flags and the held destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_done <= 1'b0;
            out_we   <= 1'b0;
            out_inv  <= 1'b0;
            out_trap <= 1'b0;
            out_data <= '0;
        end else begin
            out_done <= in_valid;
            out_we   <= in_valid && !trap_now;
            out_inv  <= in_valid && invalid;
            out_trap <= in_valid && trap_now;
            if (in_valid && !trap_now) out_data <= value;
        end
    end
endmodule

// File: rtl/f2i_conv_chk.sv
// Property checker for f2i_conv, attached through bind.
// Observes ports only.
module f2i_conv_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] in_data,
    input logic                  trunc_sel,
    input logic                  inv_mask,
    input logic                  out_done,
    input logic                  out_we,
    input logic [INT_W-1:0]      out_data,
    input logic                  out_inv,
    input logic                  out_trap
);
    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    logic [EXP_W-1:0] in_exp;
    assign in_exp = in_data[EXP_W+FRAC_W-1 -: EXP_W];

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);
    // R1
    idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_done);
    // R10
    flags_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_done |-> !(out_we || out_inv || out_trap));
    // R8
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (!out_we && out_inv && $stable(out_data)));
    // R7
    masked_indef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_inv && !out_trap) |-> (out_we && out_data == INDEF));
    // R5
    nan_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_exp) && inv_mask) |=> (out_inv && out_we && out_data == INDEF));
    // R9
    tiny_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_exp == '0) |=> !out_inv);
    // R4
    trunc_tiny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && trunc_sel && in_exp == '0) |=> (out_we && out_data == '0));
endmodule

bind f2i_conv f2i_conv_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .trunc_sel(trunc_sel), .inv_mask(inv_mask), .out_done(out_done),
    .out_we(out_we), .out_data(out_data), .out_inv(out_inv), .out_trap(out_trap)
);

// File: tb/tb_f2i_conv.sv
// Sweep bench: every exponent, several fraction patterns, both signs and all
// rounding choices, compared against exact real arithmetic.
module tb_f2i_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        trunc_sel = 1'b0;
    logic [1:0]  rmode = 2'b00;
    logic        inv_mask = 1'b1;
    logic        out_done, out_we, out_inv, out_trap;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [31:0] dest_model = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    f2i_conv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .trunc_sel(trunc_sel), .rmode(rmode), .inv_mask(inv_mask),
        .out_done(out_done), .out_we(out_we), .out_data(out_data),
        .out_inv(out_inv), .out_trap(out_trap)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Exact reference: decode to a real, round in the chosen mode, range test.
    task automatic ref_conv(input logic [31:0] b, input bit tr, input logic [1:0] rm,
                            output bit inv, output logic [31:0] v);
        int  e;
        int  ee;
        real x, f, c, d, r;
        longint li;
        e  = int'(b[30:23]);
        ee = (e == 0) ? 1 : e;
        inv = 1'b0;
        v   = 32'h8000_0000;
        if (e == 255 || e >= 170) begin
            inv = 1'b1;
            return;
        end
        x = ((e == 0) ? 0.0 : 8388608.0) + real'(b[22:0]);
        x = x * (2.0 ** (ee - 150));
        if (b[31]) x = -x;
        f = $floor(x);
        c = $ceil(x);
        if (tr) r = (x < 0.0) ? c : f;
        else begin
            case (rm)
                2'b00: begin
                    d = x - f;
                    if (d < 0.5) r = f;
                    else if (d > 0.5) r = c;
                    else begin
                        li = longint'(f);
                        r = (li % 2 == 0) ? f : c;
                    end
                end
                2'b01: r = f;
                2'b10: r = c;
                default: r = (x < 0.0) ? c : f;
            endcase
        end
        if (r > 2147483647.0 || r < -2147483648.0) begin
            inv = 1'b1;
            return;
        end
        li = longint'(r);
        v  = li[31:0];
    endtask

    task automatic run_one(input logic [31:0] b, input bit tr, input logic [1:0] rm, input bit mk);
        bit          einv, etrap;
        logic [31:0] eval, edata;
        string       tag;
        int          e;
        ref_conv(b, tr, rm, einv, eval);
        @(negedge clk);
        in_data = b; trunc_sel = tr; rmode = rm; inv_mask = mk; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        etrap = einv && !mk;
        edata = etrap ? dest_model : eval;
        e = int'(b[30:23]);
        if (etrap)          tag = "R8";
        else if (e == 255)  tag = "R5";
        else if (e >= 158)  tag = "R6";
        else if (e == 0)    tag = "R9";
        else if (tr)        tag = "R4";
        else if (rm == 0)   tag = "R2";
        else                tag = "R3";
        check(out_done == 1'b1, "R1", "done after strobe", 32'(out_done), 32'd1);
        check(out_inv == einv && out_trap == etrap && out_we == !etrap,
              tag, $sformatf("flags in=%h tr=%0d rm=%0d mk=%0d", b, tr, rm, mk),
              {29'd0, out_inv, out_trap, out_we}, {29'd0, einv, etrap, !etrap});
        check(out_data == edata, tag,
              $sformatf("data in=%h tr=%0d rm=%0d mk=%0d", b, tr, rm, mk), out_data, edata);
        if (einv && mk)
            check(out_data == 32'h8000_0000, "R7", "masked indefinite", out_data, 32'h8000_0000);
        if (!etrap) dest_model = edata;
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(!out_done && !out_we && !out_inv && !out_trap, "R10", "idle outputs",
              {28'd0, out_done, out_we, out_inv, out_trap}, 32'd0);
    endtask

    logic [31:0] fracs [6];

    initial begin
        repeat (3) @(negedge clk);
        check(out_done == 0 && out_we == 0 && out_inv == 0 && out_trap == 0 && out_data == 0,
              "R10", "reset state", out_data, 32'd0);
        rst_n = 1'b1;
        idle_check();

        // Directed ties and range edges (R2, R6).
        run_one(32'h4020_0000, 0, 2'b00, 1);  // 2.5 -> 2
        run_one(32'h4060_0000, 0, 2'b00, 1);  // 3.5 -> 4
        run_one(32'hC020_0000, 0, 2'b00, 1);  // -2.5 -> -2
        run_one(32'h3F00_0000, 0, 2'b00, 1);  // 0.5 -> 0
        run_one(32'hCF00_0000, 0, 2'b00, 1);  // -2^31 legal
        run_one(32'h4F00_0000, 0, 2'b00, 1);  // +2^31 invalid
        run_one(32'h4EFF_FFFF, 0, 2'b10, 1);  // largest below 2^31
        run_one(32'h0000_0001, 0, 2'b10, 1);  // R9 +denormal up -> 1
        run_one(32'h8000_0001, 0, 2'b01, 1);  // R9 -denormal down -> -1
        run_one(32'h8000_0000, 0, 2'b01, 1);  // R9 -0 -> 0
        idle_check();

        // Full exponent sweep, masked (R2-R7, R9).
        for (int e = 0; e < 256; e++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            fracs[0] = 32'h0;        fracs[1] = 32'h1;
            fracs[2] = 32'h40_0000;  fracs[3] = 32'h7F_FFFF;
            fracs[4] = 32'h20_0001;  fracs[5] = {9'd0, lfsr[22:0]};
            for (int fi = 0; fi < 6; fi++)
                for (int s = 0; s < 2; s++)
                    for (int m = 0; m < 5; m++)
                        run_one({s[0], e[7:0], fracs[fi][22:0]}, m == 4,
                                (m == 4) ? e[1:0] : m[1:0], 1'b1);
        end

        // Unmasked pass around the range edge and specials (R8).
        for (int e = 150; e < 162; e++)
            for (int s = 0; s < 2; s++)
                for (int m = 0; m < 5; m++)
                    run_one({s[0], e[7:0], 23'h12345}, m == 4, m[1:0], 1'b0);
        run_one(32'h7F80_0000, 0, 2'b00, 0);
        run_one(32'hFFC0_0000, 1, 2'b00, 0);
        run_one(32'h7FC0_0001, 0, 2'b11, 0);
        idle_check();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule